// File: doc/BRIEF.md
# Video Offset Calibration Loop

This block closes a digital offset loop around a three-channel video converter. Each time the clamp pulse ends, it opens a fixed sixteen-cycle calibration window. In that window it averages eight consecutive codes from every channel. It compares each average with a signed target for that channel, then moves the channel's offset correction word one step toward the target. The correction words feed the analog offset trim of the converter, so the loop settles over many lines. A small step per line keeps the picture from pumping.

Targets are signed, so a channel can be steered below black. A low target such as 40 places the sync tip inside the converter range so it can be digitized. A raised target brightens the image and a lowered one darkens it. Typical settings are 4 for ground-clamped channels and 512 for the two colour-difference channels of a component signal, which are clamped to midscale.

Software selects how often the loop runs. It can run on every line, or once per 16, 192 or 384 line syncs. It can also run exactly once and then freeze its result.

Top module: `video_offset_cal`

## Requirements
- R1: While `rst` is high, and after it is released, all three offset words read 0 and `busy` is low.
- R2: The block detects a clamp falling edge when `clamp_i` was 1 at one rising clock edge and is 0 at the next. A detected edge that is accepted makes `busy` high for exactly 16 cycles, starting the cycle after the detecting edge.
- R3: For each channel, the block averages the codes sampled in the first eight window cycles (the sum of eight codes, divided by 8 and truncated). The error is this average minus the target, and the target is 11-bit two's complement.
- R4: In the tenth window cycle, each offset word (9-bit two's complement) changes by exactly one step. A positive error decreases it by 1, a negative error increases it by 1, and a zero error leaves it unchanged. Outside that cycle the word does not change.
- R5: An offset word never wraps around. It stays at +255 when asked to increase and at -256 when asked to decrease.
- R6: A clamp falling edge seen while `busy` is high is ignored. The window neither restarts nor lengthens, and only one step is applied.
- R7: A window starts only if an update token is armed. Reset arms the token, and so does the rising edge of `cal_en`. Each window consumes the token. The token is re-armed after N rising edges of `hsync_i`, where N is 1, 16, 192 or 384 for `rate_sel` values 0, 1, 2 and 3. A clamp edge with no armed token starts no window.
- R8: While `hold_once` is high, only one window completes, and later clamp edges start nothing. Dropping `hold_once` lets windows run again.
- R9: While `cal_en` is low, no window starts and the offset words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| clamp_i | input | 1 | Clamp pulse; its falling edge opens a window |
| hsync_i | input | 1 | Line sync; rising edges are counted |
| cal_en | input | 1 | Calibration enable |
| hold_once | input | 1 | 1 = single update then freeze, 0 = continuous |
| rate_sel | input | 2 | Line interval select (1/16/192/384 lines) |
| ch0_code | input | 10 | Channel 0 converter code, unsigned |
| ch1_code | input | 10 | Channel 1 converter code, unsigned |
| ch2_code | input | 10 | Channel 2 converter code, unsigned |
| ch0_target | input | 11 | Channel 0 target, two's complement |
| ch1_target | input | 11 | Channel 1 target, two's complement |
| ch2_target | input | 11 | Channel 2 target, two's complement |
| ch0_offs | output | 9 | Channel 0 offset correction, two's complement |
| ch1_offs | output | 9 | Channel 1 offset correction, two's complement |
| ch2_offs | output | 9 | Channel 2 offset correction, two's complement |
| busy | output | 1 | High during the 16-cycle window |

## Verification
A corrupted accumulator or error register shows up on the offset port as a step in the wrong direction or a missing step. It appears within ten cycles of the clamp edge, and at the latest it is visible once the window closes. A window counter that slips shows up at once as a `busy` pulse that is not 16 cycles long. A wrong line counter or token appears only at the next clamp edge, as a window that runs when it should not, or one that does not run when it should. The bench therefore tries clamp edges on both sides of each interval boundary.

// File: rtl/vofc_pkg.sv
`timescale 1ns/1ps
package vofc_pkg;

    localparam int CODE_W     = 10;
    localparam int TGT_W      = 11;
    localparam int OFF_W      = 9;
    localparam int NCH        = 3;
    localparam int WIN_LEN    = 16;
    localparam int SAMP_N     = 8;
    localparam int SAMP_LG    = $clog2(SAMP_N);
    localparam int ACC_W      = CODE_W + SAMP_LG;
    localparam int ERR_W      = TGT_W + 1;
    localparam int WCNT_W     = $clog2(WIN_LEN);
    localparam int LINE_CNT_W = 9;

    localparam logic [WCNT_W-1:0] ERR_SLOT  = WCNT_W'(SAMP_N);
    localparam logic [WCNT_W-1:0] UPD_SLOT  = WCNT_W'(SAMP_N + 1);
    localparam logic [WCNT_W-1:0] LAST_SLOT = WCNT_W'(WIN_LEN - 1);

    typedef logic        [CODE_W-1:0] code_t;
    typedef logic signed [TGT_W-1:0]  target_t;
    typedef logic signed [OFF_W-1:0]  offs_t;
    typedef logic signed [ERR_W-1:0]  err_t;

    localparam offs_t OFF_MAX = offs_t'((2 ** (OFF_W - 1)) - 1);
    localparam offs_t OFF_MIN = offs_t'(-(2 ** (OFF_W - 1)));

    typedef enum logic [1:0] {
        PH_GATHER,
        PH_ERROR,
        PH_APPLY,
        PH_SETTLE
    } phase_e;

    typedef struct packed {
        logic   active;
        phase_e phase;
        logic   first;
    } slot_t;

    // Number of line syncs between updates for each rate code.
    function automatic logic [LINE_CNT_W-1:0] lines_per_update(input logic [1:0] sel);
        case (sel)
            2'd0:    lines_per_update = LINE_CNT_W'(1);
            2'd1:    lines_per_update = LINE_CNT_W'(16);
            2'd2:    lines_per_update = LINE_CNT_W'(192);
            default: lines_per_update = LINE_CNT_W'(384);
        endcase
    endfunction

    function automatic phase_e phase_of(input logic [WCNT_W-1:0] c);
        if (c < ERR_SLOT)       phase_of = PH_GATHER;
        else if (c == ERR_SLOT) phase_of = PH_ERROR;
        else if (c == UPD_SLOT) phase_of = PH_APPLY;
        else                    phase_of = PH_SETTLE;
    endfunction

    // One saturating unit step against the sign of the error.
    function automatic offs_t step_offset(input offs_t cur, input err_t e);
        if (e > 0 && cur != OFF_MIN)      step_offset = cur - offs_t'(1);
        else if (e < 0 && cur != OFF_MAX) step_offset = cur + offs_t'(1);
        else                              step_offset = cur;
    endfunction

endpackage

// File: rtl/vofc_line_cadence.sv
`timescale 1ns/1ps
module vofc_line_cadence
    import vofc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_en,
    input  logic       hsync_i,
    input  logic [1:0] rate_sel,
    input  logic       consume,
    output logic       token
);

    localparam logic [LINE_CNT_W-1:0] LINE_CEIL = LINE_CNT_W'(384);

    logic                  hs_q;
    logic                  hs_rise;
    logic [LINE_CNT_W-1:0] lines;

    assign hs_rise = hsync_i & ~hs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q  <= 1'b0;
            lines <= '0;
            token <= 1'b1;
        end else begin
            hs_q <= hsync_i;
            if (!cal_en) begin
                lines <= '0;
                token <= 1'b1;
            end else begin
                if (consume) token <= 1'b0;
                if (hs_rise) begin
                    if (lines + 1'b1 >= lines_per_update(rate_sel)) begin
                        lines <= '0;
                        token <= 1'b1;
                    end else begin
                        lines <= lines + 1'b1;
                    end
                end
            end
        end
    end

    // R7
    start_token_chk: assert property (@(posedge clk) disable iff (rst)
        consume |-> token);

    // R7
    line_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lines < LINE_CEIL);

endmodule

// File: rtl/vofc_window_seq.sv
`timescale 1ns/1ps
module vofc_window_seq
    import vofc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clamp_i,
    input  logic  cal_en,
    input  logic  hold_once,
    input  logic  token,
    output logic  start,
    output logic  busy,
    output slot_t slot
);

    logic              clamp_q;
    logic              clamp_fall;
    logic              done_once;
    logic [WCNT_W-1:0] wcnt;

    assign clamp_fall = clamp_q & ~clamp_i;
    assign start      = clamp_fall & cal_en & token & ~busy & ~(hold_once & done_once);

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_q   <= 1'b0;
            busy      <= 1'b0;
            wcnt      <= '0;
            done_once <= 1'b0;
        end else begin
            clamp_q <= clamp_i;
            if (start) begin
                busy <= 1'b1;
                wcnt <= '0;
            end else if (busy) begin
                wcnt <= wcnt + 1'b1;
                if (wcnt == LAST_SLOT) begin
                    busy <= 1'b0;
                    if (hold_once) done_once <= 1'b1;
                end
            end
            if (!hold_once || !cal_en) done_once <= 1'b0;
        end
    end

    always_comb begin
        slot.active = busy;
        slot.phase  = phase_of(wcnt);
        slot.first  = (wcnt == '0);
    end

    // R6
    clamp_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && clamp_fall && wcnt != LAST_SLOT) |=> (busy && wcnt == $past(wcnt) + 1'b1));

endmodule

// File: rtl/vofc_chan_corr.sv
`timescale 1ns/1ps
module vofc_chan_corr
    import vofc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  slot_t   slot,
    input  code_t   code,
    input  target_t target,
    output offs_t   offs
);

    logic [ACC_W-1:0] acc;
    err_t             err;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            err  <= '0;
            offs <= '0;
        end else if (slot.active) begin
            case (slot.phase)
                PH_GATHER: acc  <= slot.first ? ACC_W'(code) : acc + ACC_W'(code);
                PH_ERROR:  err  <= err_t'({1'b0, acc[ACC_W-1:SAMP_LG]}) - err_t'(target);
                PH_APPLY:  offs <= step_offset(offs, err);
                default:   ;
            endcase
        end
    end

    // R4
    off_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(offs) |-> $past(slot.active && slot.phase == PH_APPLY));

    // R5
    off_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(offs) |-> (offs == $past(offs) + 1 || offs == $past(offs) - 1));

endmodule

// File: rtl/video_offset_cal.sv
`timescale 1ns/1ps
module video_offset_cal
    import vofc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clamp_i,
    input  logic              hsync_i,
    input  logic              cal_en,
    input  logic              hold_once,
    input  logic [1:0]        rate_sel,
    input  logic [9:0]        ch0_code,
    input  logic [9:0]        ch1_code,
    input  logic [9:0]        ch2_code,
    input  logic signed [10:0] ch0_target,
    input  logic signed [10:0] ch1_target,
    input  logic signed [10:0] ch2_target,
    output logic signed [8:0] ch0_offs,
    output logic signed [8:0] ch1_offs,
    output logic signed [8:0] ch2_offs,
    output logic              busy
);

    localparam logic [WCNT_W:0] RUN_FULL = WIN_LEN[WCNT_W:0];

    logic    token;
    logic    start;
    slot_t   slot;
    code_t   codes   [NCH];
    target_t targets [NCH];
    offs_t   offs    [NCH];

    assign codes[0]   = ch0_code;
    assign codes[1]   = ch1_code;
    assign codes[2]   = ch2_code;
    assign targets[0] = ch0_target;
    assign targets[1] = ch1_target;
    assign targets[2] = ch2_target;
    assign ch0_offs   = offs[0];
    assign ch1_offs   = offs[1];
    assign ch2_offs   = offs[2];

    vofc_line_cadence u_cadence (
        .clk      (clk),
        .rst      (rst),
        .cal_en   (cal_en),
        .hsync_i  (hsync_i),
        .rate_sel (rate_sel),
        .consume  (start),
        .token    (token)
    );

    vofc_window_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .clamp_i   (clamp_i),
        .cal_en    (cal_en),
        .hold_once (hold_once),
        .token     (token),
        .start     (start),
        .busy      (busy),
        .slot      (slot)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        vofc_chan_corr u_chan (
            .clk    (clk),
            .rst    (rst),
            .slot   (slot),
            .code   (codes[gi]),
            .target (targets[gi]),
            .offs   (offs[gi])
        );
    end

    logic [WCNT_W:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == RUN_FULL);

    // R2
    busy_cap_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_run < RUN_FULL);

endmodule

// File: tb/test_video_offset_cal.sv
`timescale 1ns/1ps
module test_video_offset_cal;

    typedef struct packed {
        logic [9:0]         c0;
        logic [9:0]         c1;
        logic [9:0]         c2;
        logic signed [10:0] t0;
        logic signed [10:0] t1;
        logic signed [10:0] t2;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{10'd10,   10'd520,  10'd2,    11'sd4,    11'sd512,  11'sd4},
        '{10'd4,    10'd512,  10'd4,    11'sd4,    11'sd512,  11'sd4},
        '{10'd0,    10'd0,    10'd0,    -11'sd40,  -11'sd1,   11'sd0},
        '{10'd1023, 10'd1023, 10'd1023, 11'sd1023, 11'sd1023, -11'sd1024},
        '{10'd40,   10'd300,  10'd700,  11'sd40,   11'sd301,  11'sd699},
        '{10'd0,    10'd5,    10'd0,    11'sd1,    11'sd6,    11'sd1},
        '{10'd600,  10'd100,  10'd33,   11'sd512,  11'sd4,    11'sd40},
        '{10'd512,  10'd512,  10'd512,  11'sd512,  11'sd600,  11'sd400}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clamp_i = 1'b0;
    logic              hsync_i = 1'b0;
    logic              cal_en = 1'b1;
    logic              hold_once = 1'b0;
    logic [1:0]        rate_sel = 2'd0;
    logic [9:0]        code [3];
    logic signed [10:0] tgt [3];
    logic signed [8:0] offs [3];
    logic              busy;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_off [3];

    always #4 clk = ~clk;

    video_offset_cal i_video_offset_cal (
        .clk        (clk),
        .rst        (rst),
        .clamp_i    (clamp_i),
        .hsync_i    (hsync_i),
        .cal_en     (cal_en),
        .hold_once  (hold_once),
        .rate_sel   (rate_sel),
        .ch0_code   (code[0]),
        .ch1_code   (code[1]),
        .ch2_code   (code[2]),
        .ch0_target (tgt[0]),
        .ch1_target (tgt[1]),
        .ch2_target (tgt[2]),
        .ch0_offs   (offs[0]),
        .ch1_offs   (offs[1]),
        .ch2_offs   (offs[2]),
        .busy       (busy)
    );

    task automatic check(input string req, input int got, input int expv);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    function automatic int model_step(input int cur, input int avg, input int target);
        int e = avg - target;
        if (e > 0 && cur > -256) return cur - 1;
        if (e < 0 && cur < 255)  return cur + 1;
        return cur;
    endfunction

    task automatic pulse_hsync();
        @(negedge clk) hsync_i = 1'b1;
        @(negedge clk) hsync_i = 1'b0;
    endtask

    // Clamp pulse, then watch 20 cycles; optional alternating codes on ch0/ch1.
    task automatic run_clamp(input bit wiggle, output int nbusy);
        nbusy = 0;
        @(negedge clk) clamp_i = 1'b1;
        @(negedge clk) clamp_i = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (wiggle) begin
                code[0] = (k % 2 == 1) ? 10'd108 : 10'd100;
                code[1] = (k % 2 == 1) ? 10'd116 : 10'd100;
            end
            if (busy) nbusy++;
        end
    endtask

    task automatic check_offs(input string req);
        for (int c = 0; c < 3; c++) check(req, int'(offs[c]), exp_off[c]);
    endtask

    task automatic set_chan(input int c, input int cv, input int tv);
        code[c] = cv[9:0];
        tgt[c]  = tv[10:0];
    endtask

    task automatic model_all();
        for (int c = 0; c < 3; c++)
            exp_off[c] = model_step(exp_off[c], int'(code[c]), int'(tgt[c]));
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int nb;
        for (int c = 0; c < 3; c++) begin
            code[c] = '0;
            tgt[c] = '0;
            exp_off[c] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: state during reset
        check("R1 busy in reset", int'(busy), 0);
        check_offs("R1 offs in reset");
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check_offs("R1 offs after reset");

        // Table walk, every-line rate: R2 length, R3/R4 step direction
        for (int i = 0; i < NV; i++) begin
            set_chan(0, int'(VECS[i].c0), int'(VECS[i].t0));
            set_chan(1, int'(VECS[i].c1), int'(VECS[i].t1));
            set_chan(2, int'(VECS[i].c2), int'(VECS[i].t2));
            pulse_hsync();
            run_clamp(1'b0, nb);
            model_all();
            check("R2 window length", nb, 16);
            check_offs("R4 table step");
        end

        // R3: average of eight alternating samples, truncated
        set_chan(0, 100, 104);
        set_chan(1, 100, 109);
        set_chan(2, 50, 50);
        pulse_hsync();
        run_clamp(1'b1, nb);
        exp_off[1] = model_step(exp_off[1], 108, 109);
        check("R3 window", nb, 16);
        check_offs("R3 averaged error");

        // R6: second clamp edge and hsync inside the window
        set_chan(0, 900, 4);
        set_chan(1, 4, 4);
        set_chan(2, 4, 4);
        pulse_hsync();
        nb = 0;
        @(negedge clk) clamp_i = 1'b1;
        @(negedge clk) clamp_i = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (k == 3) clamp_i = 1'b1;
            if (k == 4) hsync_i = 1'b1;
            if (k == 5) begin clamp_i = 1'b0; hsync_i = 1'b0; end
            if (busy) nb++;
        end
        model_all();
        check("R6 no restart", nb, 16);
        check_offs("R6 single step");

        // R7: rate 2 = 192 lines (token armed from the hsync above)
        rate_sel = 2'd2;
        run_clamp(1'b0, nb);
        model_all();
        check("R7 armed window", nb, 16);
        for (int k = 0; k < 191; k++) pulse_hsync();
        run_clamp(1'b0, nb);
        check("R7 191 lines no window", nb, 0);
        check_offs("R7 no step at 191");
        pulse_hsync();
        run_clamp(1'b0, nb);
        model_all();
        check("R7 192 lines window", nb, 16);
        check_offs("R7 step at 192");

        // R7: rate 1 = 16 lines
        rate_sel = 2'd1;
        for (int k = 0; k < 15; k++) pulse_hsync();
        run_clamp(1'b0, nb);
        check("R7 15 lines no window", nb, 0);
        pulse_hsync();
        run_clamp(1'b0, nb);
        model_all();
        check("R7 16 lines window", nb, 16);
        check_offs("R7 step at 16");

        // R8: one-shot hold
        rate_sel = 2'd0;
        hold_once = 1'b1;
        pulse_hsync();
        run_clamp(1'b0, nb);
        model_all();
        check("R8 first window", nb, 16);
        pulse_hsync();
        run_clamp(1'b0, nb);
        check("R8 frozen no window", nb, 0);
        check_offs("R8 frozen offsets");
        hold_once = 1'b0;
        pulse_hsync();
        run_clamp(1'b0, nb);
        model_all();
        check("R8 released window", nb, 16);
        check_offs("R8 released step");

        // R9: disabled
        @(negedge clk) cal_en = 1'b0;
        pulse_hsync();
        run_clamp(1'b0, nb);
        check("R9 disabled no window", nb, 0);
        check_offs("R9 offsets kept");
        // R7: enable rising edge arms a token without any hsync
        @(negedge clk) cal_en = 1'b1;
        run_clamp(1'b0, nb);
        model_all();
        check("R7 enable arms token", nb, 16);
        check_offs("R7 enable step");

        // R5: drive both limits
        set_chan(0, 0, 1000);
        set_chan(1, 1023, -1024);
        set_chan(2, 0, 1000);
        for (int k = 0; k < 300; k++) begin
            pulse_hsync();
            run_clamp(1'b0, nb);
            model_all();
        end
        check("R5 upper limit", int'(offs[0]), 255);
        check("R5 lower limit", int'(offs[1]), -256);
        check_offs("R5 saturated model");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule